// File: doc/BRIEF.md
# Power-Up Strap Latch and Output Mode Decoder

This block reads a small set of shared pins during a short window that opens when the power-on reset is released. While the window is open, the pins act as configuration inputs and every output enable is held low. On the last cycle of the window the block captures the pin levels together with the CPU speed select. It then keeps that configuration until the next power-on reset and releases the shared pins to act as clock outputs.

The captured levels are decoded into three things:
- a two-bit operating mode;
- frequency-select codes for the synthesizers that drive the CPU, PCI, fixed 48 MHz and selectable 48/24 MHz outputs;
- a spread-spectrum enable, together with per-pin output enables and a global high-impedance request.

The spread-spectrum enable asks for a down-spread of about 1.5 %, with the maximum frequency at nominal. The pads and the synthesizers are not part of this block; they consume its codes and enables.

Top module: `pwrup_strap_decoder`

## Requirements
- R1: After `por_n` rises, `window_open_o` stays high for exactly `WIN_CYC` rising clock edges and then falls. While it is high (and during reset), `ref_oe_o`, `fix_oe_o` and `clk_oe_o` are all 0, and `cfg_valid_o` is 0.
- R2: The configuration is taken from the pin levels present at the last rising edge of the window (edge number `WIN_CYC` after reset release). Levels applied before that edge have no effect on the result.
- R3: `spread_en_o` is 1 when `spread_pin_i` was captured low, and 0 when it was captured high.
- R4: `sel24_o` equals the captured level of `fsel_pin_i`. Outside test mode, `fix_fsel_o` is 2'b00 (48 MHz) when the captured level is low and 2'b01 (24 MHz) when it is high.
- R5: `mode_o` is built from the captured tri-state pin `tsel_pin_i` and the speed select `cpu_speed_i`:
  - tsel=0, speed=0 gives 2'b00 (tri-state);
  - tsel=1, speed=0 gives 2'b01 (normal, 66.66 MHz);
  - tsel=1, speed=1 gives 2'b10 (normal, 100 MHz);
  - tsel=0, speed=1 gives 2'b11 (test).
- R6: In tri-state mode, once the configuration is valid, `out_hiz_o` is 1 and every output enable is 0. This persists until the next power-on reset. In every other mode `out_hiz_o` is 0 and all enables are 1 once valid.
- R7: In the normal modes:
  - `cpu_fsel_o` is 2'b00 for 66.66 MHz and 2'b01 for 100 MHz;
  - `pci_fsel_o` is 0 (33.33 MHz);
  - `usb_fsel_o` is 0 (48 MHz).
- R8: In test mode:
  - `cpu_fsel_o` is 2'b10 (7.16 MHz);
  - `pci_fsel_o` is 1 (2.38 MHz);
  - `usb_fsel_o` is 1 (7.16 MHz);
  - `fix_fsel_o` is 2'b10 (7.16 MHz) when `sel24_o` is 0 and 2'b11 (3.58 MHz) when it is 1.
  
  In tri-state mode `cpu_fsel_o` is parked at 2'b11.
- R9: `ssc_on_o` (the modulation request to the synthesizer) is 1 only when spread is enabled and the mode is one of the two normal modes.
- R10: After capture, changes on any strap pin or on `cpu_speed_i` leave every output unchanged until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| spread_pin_i | input | 1 | Shared pin level, spread strap (low = spread on) |
| fsel_pin_i | input | 1 | Shared pin level, selectable-output strap (low = 48 MHz) |
| tsel_pin_i | input | 1 | Shared pin level, tri-state/test strap |
| cpu_speed_i | input | 1 | CPU speed select (high = 100 MHz) |
| window_open_o | output | 1 | Strap sampling window active |
| cfg_valid_o | output | 1 | Configuration captured |
| mode_o | output | 2 | Latched mode field |
| spread_en_o | output | 1 | Latched spread-spectrum enable |
| sel24_o | output | 1 | Latched 24 MHz selection |
| ssc_on_o | output | 1 | Down-spread modulation request |
| cpu_fsel_o | output | 2 | CPU synthesizer frequency code |
| pci_fsel_o | output | 1 | PCI frequency code |
| usb_fsel_o | output | 1 | Fixed 48 MHz output frequency code |
| fix_fsel_o | output | 2 | Selectable output frequency code |
| ref_oe_o | output | N_REF | Output enables of the shared reference pins |
| fix_oe_o | output | 1 | Output enable of the selectable-output pin |
| clk_oe_o | output | 1 | Output enable of the dedicated clock pins |
| out_hiz_o | output | 1 | Global high-impedance request |

## Verification
A window counter that is off by one cycle shows at the ports in two ways: the enables rise one edge early or late, and the result captures the pin levels of the wrong edge. The bench therefore holds the inverted levels until just before the final window edge, so a mis-timed capture shows up as a wrong mode right after the window closes. A corrupted mode register or decode appears immediately in the frequency codes and enables. A register that reloads after capture is exposed within three cycles, once the pins are flipped.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_N66  = 2'b01,
    MODE_N100 = 2'b10,
    MODE_TEST = 2'b11
  } mode_e;

  function automatic mode_e mode_of(input logic tsel, input logic speed);
    return mode_e'({speed, tsel ^ speed});
  endfunction

  function automatic logic [1:0] cpu_code(input mode_e m);
    case (m)
      MODE_N66:  return 2'b00;
      MODE_N100: return 2'b01;
      MODE_TEST: return 2'b10;
      default:   return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] fix_code(input mode_e m, input logic sel24);
    return {m == MODE_TEST, sel24};
  endfunction

  function automatic logic is_normal(input mode_e m);
    return (m == MODE_N66) || (m == MODE_N100);
  endfunction
endpackage

// File: rtl/strap_window.sv
module strap_window #(
  parameter int WIN_CYC = 8
) (
  input  logic clk,
  input  logic por_n,
  output logic open_o,
  output logic capture_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign open_o    = !done_q;
  assign capture_o = !done_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  capture_i,
  input  logic  spread_pin_i,
  input  logic  fsel_pin_i,
  input  logic  tsel_pin_i,
  input  logic  cpu_speed_i,
  output mode_e mode_o,
  output logic  spread_en_o,
  output logic  sel24_o,
  output logic  valid_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_o      <= MODE_HIZ;
      spread_en_o <= 1'b0;
      sel24_o     <= 1'b0;
      valid_o     <= 1'b0;
    end else if (capture_i) begin
      mode_o      <= mode_of(tsel_pin_i, cpu_speed_i);
      spread_en_o <= !spread_pin_i;
      sel24_o     <= fsel_pin_i;
      valid_o     <= 1'b1;
    end
  end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import strap_pkg::*;
#(
  parameter int N_REF = 2
) (
  input  mode_e            mode_i,
  input  logic             spread_en_i,
  input  logic             sel24_i,
  input  logic             valid_i,
  output logic             ssc_on_o,
  output logic [1:0]       cpu_fsel_o,
  output logic             pci_fsel_o,
  output logic             usb_fsel_o,
  output logic [1:0]       fix_fsel_o,
  output logic [N_REF-1:0] ref_oe_o,
  output logic             fix_oe_o,
  output logic             clk_oe_o,
  output logic             out_hiz_o
);
  logic drive_en;
  logic test_m;

  assign test_m     = (mode_i == MODE_TEST);
  assign drive_en   = valid_i && (mode_i != MODE_HIZ);
  assign out_hiz_o  = valid_i && (mode_i == MODE_HIZ);
  assign ssc_on_o   = spread_en_i && is_normal(mode_i);
  assign cpu_fsel_o = cpu_code(mode_i);
  assign pci_fsel_o = test_m;
  assign usb_fsel_o = test_m;
  assign fix_fsel_o = fix_code(mode_i, sel24_i);
  assign fix_oe_o   = drive_en;
  assign clk_oe_o   = drive_en;

  for (genvar g = 0; g < N_REF; g++) begin : g_ref_oe
    assign ref_oe_o[g] = drive_en;
  end
endmodule

// File: rtl/pwrup_strap_decoder.sv
module pwrup_strap_decoder
  import strap_pkg::*;
#(
  parameter int WIN_CYC = 8,
  parameter int N_REF   = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             spread_pin_i,
  input  logic             fsel_pin_i,
  input  logic             tsel_pin_i,
  input  logic             cpu_speed_i,
  output logic             window_open_o,
  output logic             cfg_valid_o,
  output logic [1:0]       mode_o,
  output logic             spread_en_o,
  output logic             sel24_o,
  output logic             ssc_on_o,
  output logic [1:0]       cpu_fsel_o,
  output logic             pci_fsel_o,
  output logic             usb_fsel_o,
  output logic [1:0]       fix_fsel_o,
  output logic [N_REF-1:0] ref_oe_o,
  output logic             fix_oe_o,
  output logic             clk_oe_o,
  output logic             out_hiz_o
);
  logic  cap_pulse;
  mode_e mode_q;

  assign mode_o = mode_q;

  strap_window #(.WIN_CYC(WIN_CYC)) win_i (
    .clk       (clk),
    .por_n     (por_n),
    .open_o    (window_open_o),
    .capture_o (cap_pulse)
  );

  strap_latch lat_i (
    .clk          (clk),
    .por_n        (por_n),
    .capture_i    (cap_pulse),
    .spread_pin_i (spread_pin_i),
    .fsel_pin_i   (fsel_pin_i),
    .tsel_pin_i   (tsel_pin_i),
    .cpu_speed_i  (cpu_speed_i),
    .mode_o       (mode_q),
    .spread_en_o  (spread_en_o),
    .sel24_o      (sel24_o),
    .valid_o      (cfg_valid_o)
  );

  mode_decode #(.N_REF(N_REF)) dec_i (
    .mode_i      (mode_q),
    .spread_en_i (spread_en_o),
    .sel24_i     (sel24_o),
    .valid_i     (cfg_valid_o),
    .ssc_on_o    (ssc_on_o),
    .cpu_fsel_o  (cpu_fsel_o),
    .pci_fsel_o  (pci_fsel_o),
    .usb_fsel_o  (usb_fsel_o),
    .fix_fsel_o  (fix_fsel_o),
    .ref_oe_o    (ref_oe_o),
    .fix_oe_o    (fix_oe_o),
    .clk_oe_o    (clk_oe_o),
    .out_hiz_o   (out_hiz_o)
  );
endmodule

// File: rtl/strap_decoder_chk.sv
module strap_decoder_chk #(
  parameter int N_REF = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic             cap_pulse,
  input logic             window_open_o,
  input logic             cfg_valid_o,
  input logic [1:0]       mode_o,
  input logic             spread_en_o,
  input logic             sel24_o,
  input logic             ssc_on_o,
  input logic [1:0]       cpu_fsel_o,
  input logic             pci_fsel_o,
  input logic             usb_fsel_o,
  input logic [N_REF-1:0] ref_oe_o,
  input logic             fix_oe_o,
  input logic             clk_oe_o,
  input logic             out_hiz_o
);
  AST_WINDOW_OE_OFF: assert property (@(posedge clk) disable iff (!por_n)
    window_open_o |-> (ref_oe_o == '0) && !fix_oe_o && !clk_oe_o && !cfg_valid_o); // R1
  AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (!por_n)
    cap_pulse |=> cfg_valid_o && !window_open_o); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    cfg_valid_o |=> $stable(mode_o) && $stable(spread_en_o) && $stable(sel24_o)); // R10
  AST_HIZ_NO_OE: assert property (@(posedge clk) disable iff (!por_n)
    out_hiz_o |-> (ref_oe_o == '0) && !fix_oe_o && !clk_oe_o); // R6
  AST_HIZ_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    out_hiz_o |=> out_hiz_o); // R6
  AST_TEST_CODES: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_valid_o && mode_o == 2'b11) |-> (cpu_fsel_o == 2'b10) && pci_fsel_o && usb_fsel_o); // R8
  AST_SSC_NORMAL: assert property (@(posedge clk) disable iff (!por_n)
    ssc_on_o |-> spread_en_o && (mode_o == 2'b01 || mode_o == 2'b10)); // R9
endmodule

bind pwrup_strap_decoder strap_decoder_chk #(.N_REF(N_REF)) chk_i (
  .clk           (clk),
  .por_n         (por_n),
  .cap_pulse     (cap_pulse),
  .window_open_o (window_open_o),
  .cfg_valid_o   (cfg_valid_o),
  .mode_o        (mode_o),
  .spread_en_o   (spread_en_o),
  .sel24_o       (sel24_o),
  .ssc_on_o      (ssc_on_o),
  .cpu_fsel_o    (cpu_fsel_o),
  .pci_fsel_o    (pci_fsel_o),
  .usb_fsel_o    (usb_fsel_o),
  .ref_oe_o      (ref_oe_o),
  .fix_oe_o      (fix_oe_o),
  .clk_oe_o      (clk_oe_o),
  .out_hiz_o     (out_hiz_o)
);

// File: tb/pwrup_strap_decoder_tb_top.sv
module pwrup_strap_decoder_tb_top;
  localparam int WIN = 8;
  localparam int NR  = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ss_p = 1'b0, fs_p = 1'b0, ts_p = 1'b0, sp_p = 1'b0;
  logic win_o, val_o, ssen_o, s24_o, sscon_o, pci_o, usb_o, foe_o, coe_o, hiz_o;
  logic [1:0] mode_o, cpu_o, fix_o;
  logic [NR-1:0] roe_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pwrup_strap_decoder #(.WIN_CYC(WIN), .N_REF(NR)) dut_i (
    .clk(clk), .por_n(por_n), .spread_pin_i(ss_p), .fsel_pin_i(fs_p),
    .tsel_pin_i(ts_p), .cpu_speed_i(sp_p), .window_open_o(win_o),
    .cfg_valid_o(val_o), .mode_o(mode_o), .spread_en_o(ssen_o), .sel24_o(s24_o),
    .ssc_on_o(sscon_o), .cpu_fsel_o(cpu_o), .pci_fsel_o(pci_o), .usb_fsel_o(usb_o),
    .fix_fsel_o(fix_o), .ref_oe_o(roe_o), .fix_oe_o(foe_o), .clk_oe_o(coe_o),
    .out_hiz_o(hiz_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {ss_p, fs_p, ts_p, sp_p} = v;
  endtask

  task automatic check_cfg(input logic [3:0] v);
    logic ss, fs, ts, sp;
    int m, ecpu, efix, enorm, oe;
    {ss, fs, ts, sp} = v;
    if (!ts && !sp)     m = 0;
    else if (ts && !sp) m = 1;
    else if (ts && sp)  m = 2;
    else                m = 3;
    ecpu  = (m == 0) ? 3 : m - 1;
    efix  = (m == 3) ? (fs ? 3 : 2) : (fs ? 1 : 0);
    enorm = (m == 1 || m == 2) ? 1 : 0;
    oe    = (m != 0) ? 1 : 0;
    chk("R1 valid after window", int'(val_o), 1);
    chk("R1 window closed", int'(win_o), 0);
    chk("R5 mode", int'(mode_o), m);
    chk("R3 spread", int'(ssen_o), ss ? 0 : 1);
    chk("R4 sel24", int'(s24_o), int'(fs));
    chk("R4 R8 fix code", int'(fix_o), efix);
    chk("R7 R8 cpu code", int'(cpu_o), ecpu);
    chk("R7 R8 pci code", int'(pci_o), (m == 3) ? 1 : 0);
    chk("R7 R8 usb code", int'(usb_o), (m == 3) ? 1 : 0);
    chk("R9 ssc on", int'(sscon_o), (!ss && enorm == 1) ? 1 : 0);
    chk("R6 hiz", int'(hiz_o), (m == 0) ? 1 : 0);
    chk("R6 ref oe", int'(roe_o), oe ? (1 << NR) - 1 : 0);
    chk("R6 fix oe", int'(foe_o), oe);
    chk("R6 clk oe", int'(coe_o), oe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) begin
      logic [3:0] v;
      v = 4'(c);
      @(negedge clk);
      por_n = 1'b0;
      drive(~v);
      repeat (2) @(negedge clk);
      chk("R1 reset window", int'(win_o), 1);
      chk("R1 reset oe off", int'({roe_o, foe_o, coe_o, val_o}), 0);
      por_n = 1'b1;
      for (int i = 0; i < WIN; i++) begin
        chk("R1 window open", int'(win_o), 1);
        chk("R1 oe held off", int'({roe_o, foe_o, coe_o, hiz_o}), 0);
        if (i == WIN - 1) drive(v); // R2: only the last window edge counts
        @(negedge clk);
      end
      check_cfg(v);
      drive(~v);  // R10: post-capture pin changes ignored
      repeat (3) @(negedge clk);
      check_cfg(v);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule